// File: doc/BRIEF.md
# Operand Width Extension and Status Flag Unit

This unit sits between the operand fetch path and the register file of a variable-width processor core. Each valid operation delivers an operand that was read at the operation size named by the instruction's width prefix (8, 16, 32 or 64 bits). The unit also receives the extension mode, a flag that says whether an explicit second prefix byte set that mode, the opcode class, the no-flags bit, the current destination register value and the result of the ALU. From these it produces three things. The first is the operand handed to the ALU, widened to the full register width. The second is the value written back to the destination register. The third is the N and Z flags, together with their write enable.

Loads and transfers are handled completely inside the unit. Their write-back value is the extended operand, and their flags always come from the narrow value that was read. For other operations the unit only shapes the ALU operand. It then merges the ALU result back into the register at the operation width, or passes it through at full width when an extension mode is active. Stores pass the register value out at the operation width and never touch flags. All outputs are registered, so results appear one clock after the inputs are accepted. The register width `REG_W` is a parameter (16, 32 or 64).

Top module: `lx_unit`

## Requirements
- R1: Outputs are registered. `out_valid` equals the `in_valid` of the previous cycle. After reset, `out_valid`, `flag_we`, `flag_n` and `flag_z` are 0.
- R2: `op_size` 00, 01, 10 and 11 select widths of 8, 16, 32 and 64 bits. A width larger than `REG_W` is clamped to `REG_W`, and `operand` is then truncated to its low `REG_W` bits.
- R3: Effective extension mode 00 (none) keeps the bits of `reg_value` above the operation width. Only the low operation-width bits come from the new value.
- R4: Mode 01 (sign) fills the bits above the operation width with the operand's top bit at that width.
- R5: Mode 10 (zero) clears the bits above the operation width.
- R6: Mode 11 (ones) sets the bits above the operation width.
- R7: When `ext_explicit` is 0, the effective mode is 10 for the load/transfer class (`op_class` 01) and 00 for the other class (00) and the compare class (10). When `ext_explicit` is 1, the effective mode is `ext_mode`.
- R8: For classes 00 and 10, `alu_operand` is the extended operand. `wb_value` is `alu_result` merged at the operation width under mode 00, and all of `alu_result` under any other mode.
- R9: For loads and transfers, `alu_operand` and `wb_value` both equal the extended operand. N and Z come from the operand at the operation width, whatever the mode.
- R10: For classes 00 and 10, N and Z come from `alu_result` at the operation width under mode 00, and at full `REG_W` width otherwise. N is the top bit of the source width, and Z is 1 when the source is zero at that width.
- R11: `flag_we` is 1 for every valid compare. For the other non-store classes it is 1 only when `no_flags` is 0. Whenever `flag_we` is 0, `flag_n` and `flag_z` are 0.
- R12: Store class (`op_class` 11) ignores the extension inputs. Its `alu_operand` is `reg_value` at the operation width with the upper bits zero, its `wb_value` equals `reg_value`, and `flag_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_class | input | 2 | 00 other, 01 load/transfer, 10 compare, 11 store |
| op_size | input | 2 | Operation width: 00=8, 01=16, 10=32, 11=64 bits |
| ext_mode | input | 2 | 00 none, 01 sign, 10 zero, 11 ones |
| ext_explicit | input | 1 | Extension mode was given by an explicit prefix |
| no_flags | input | 1 | Suppress flag update (not for compares) |
| operand | input | 64 | Operand read at operation width |
| reg_value | input | REG_W | Current destination register value |
| alu_result | input | REG_W | ALU result for non-load classes |
| out_valid | output | 1 | Registered results valid |
| alu_operand | output | REG_W | Extended operand for the ALU, or store data |
| wb_value | output | REG_W | Register write-back value |
| flag_we | output | 1 | Write N and Z |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bound checker watches, on every cycle, the invariants that can be stated from the ports alone. These are the one-cycle valid pipeline, the preservation of the upper register bits under an explicit no-extension load, the cleared upper bits under a default load, the set upper bits under ones-extension, the flag-write rules for no-flags, compares and stores, and the unchanged write-back for stores. The width clamping, sign selection at each width, the choice between narrow-width and full-width flag sources, and the merge of ALU results can only be shown by the bench's scenarios. Those scenarios compare every output against a behavioural model on every clock.

// File: rtl/lx_pkg.sv
package lx_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_CMP   = 2'b10,
    CLS_STORE = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    EXT_NONE = 2'b00,
    EXT_SIGN = 2'b01,
    EXT_ZERO = 2'b10,
    EXT_ONES = 2'b11
  } ext_mode_e;

  localparam int MAX_OP_W = 64;

endpackage

// File: rtl/lx_width_dec.sv
module lx_width_dec #(
  parameter int REG_W = 64
) (
  input  logic [1:0]       op_size,
  output logic [REG_W-1:0] width_mask,
  output logic [REG_W-1:0] msb_sel
);
  // Width in bits selected by the size code, clamped to the register width.
  function automatic int size_bits(input logic [1:0] sz);
    int w;
    w = 8 << sz;
    if (w > REG_W) w = REG_W;
    return w;
  endfunction

  int w_bits;
  always_comb w_bits = size_bits(op_size);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    assign width_mask[i] = (i < w_bits);
    assign msb_sel[i]    = (w_bits == i + 1);
  end
endmodule

// File: rtl/lx_extend.sv
module lx_extend
  import lx_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0] value,
  input  logic [REG_W-1:0] keep_bits,
  input  logic [REG_W-1:0] width_mask,
  input  logic [REG_W-1:0] msb_sel,
  input  ext_mode_e        mode,
  output logic [REG_W-1:0] extended
);
  // Upper-part fill pattern for each mode; the low part always comes from value.
  function automatic logic [REG_W-1:0] fill_for(
    input ext_mode_e m, input logic sgn, input logic [REG_W-1:0] keep);
    case (m)
      EXT_NONE: return keep;
      EXT_SIGN: return {REG_W{sgn}};
      EXT_ZERO: return '0;
      default:  return '1;
    endcase
  endfunction

  logic top_bit;
  assign top_bit  = |(value & msb_sel);
  assign extended = (value & width_mask) |
                    (fill_for(mode, top_bit, keep_bits) & ~width_mask);
endmodule

// File: rtl/lx_flags.sv
module lx_flags #(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] width_mask,
  input  logic [REG_W-1:0] msb_sel,
  output logic             neg,
  output logic             zero
);
  assign neg  = |(src & msb_sel);
  assign zero = ~|(src & width_mask);
endmodule

// File: rtl/lx_unit.sv
module lx_unit
  import lx_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op_class,
  input  logic [1:0]       op_size,
  input  logic [1:0]       ext_mode,
  input  logic             ext_explicit,
  input  logic             no_flags,
  input  logic [63:0]      operand,
  input  logic [REG_W-1:0] reg_value,
  input  logic [REG_W-1:0] alu_result,
  output logic             out_valid,
  output logic [REG_W-1:0] alu_operand,
  output logic [REG_W-1:0] wb_value,
  output logic             flag_we,
  output logic             flag_n,
  output logic             flag_z
);
  localparam int OPW = (REG_W < MAX_OP_W) ? REG_W : MAX_OP_W;

  op_class_e        cls;
  ext_mode_e        eff_mode;
  logic [REG_W-1:0] opnd_t;
  logic [REG_W-1:0] w_mask, w_msb;
  logic [REG_W-1:0] ext_in, ext_keep, ext_out;
  logic [REG_W-1:0] fsrc, fmask, fmsb;
  logic [REG_W-1:0] wb_d;
  logic             is_load, is_store, flag_narrow;
  logic             n_d, z_d, fl_we_d;

  assign cls      = op_class_e'(op_class);
  assign is_load  = (cls == CLS_LOAD);
  assign is_store = (cls == CLS_STORE);

  always_comb begin
    opnd_t = '0;
    opnd_t[OPW-1:0] = operand[OPW-1:0];
  end

  // Effective extension mode after class defaults and store override.
  always_comb begin
    if (is_store)          eff_mode = EXT_NONE;
    else if (ext_explicit) eff_mode = ext_mode_e'(ext_mode);
    else if (is_load)      eff_mode = EXT_ZERO;
    else                   eff_mode = EXT_NONE;
  end

  lx_width_dec #(.REG_W(REG_W)) u_wdec (
    .op_size    (op_size),
    .width_mask (w_mask),
    .msb_sel    (w_msb)
  );

  assign ext_in   = is_store ? reg_value : opnd_t;
  assign ext_keep = is_store ? '0 : reg_value;

  lx_extend #(.REG_W(REG_W)) u_ext (
    .value      (ext_in),
    .keep_bits  (ext_keep),
    .width_mask (w_mask),
    .msb_sel    (w_msb),
    .mode       (eff_mode),
    .extended   (ext_out)
  );

  // Write-back selection per class.
  always_comb begin
    if (is_load)                   wb_d = ext_out;
    else if (is_store)             wb_d = reg_value;
    else if (eff_mode == EXT_NONE) wb_d = (alu_result & w_mask) | (reg_value & ~w_mask);
    else                           wb_d = alu_result;
  end

  // Flag source: narrow for loads and unextended ops, full width otherwise.
  assign flag_narrow = is_load || (eff_mode == EXT_NONE);
  assign fsrc  = is_load ? opnd_t : alu_result;
  assign fmask = flag_narrow ? w_mask : '1;
  always_comb begin
    fmsb = '0;
    if (flag_narrow) fmsb = w_msb;
    else             fmsb[REG_W-1] = 1'b1;
  end

  lx_flags #(.REG_W(REG_W)) u_flags (
    .src        (fsrc),
    .width_mask (fmask),
    .msb_sel    (fmsb),
    .neg        (n_d),
    .zero       (z_d)
  );

  assign fl_we_d = in_valid && !is_store && ((cls == CLS_CMP) || !no_flags);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      alu_operand <= '0;
      wb_value    <= '0;
      flag_we     <= 1'b0;
      flag_n      <= 1'b0;
      flag_z      <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      alu_operand <= ext_out;
      wb_value    <= wb_d;
      flag_we     <= fl_we_d;
      flag_n      <= fl_we_d & n_d;
      flag_z      <= fl_we_d & z_d;
    end
  end
endmodule

// File: rtl/lx_unit_chk.sv
module lx_unit_chk #(
  parameter int REG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op_class,
  input logic [1:0]       op_size,
  input logic [1:0]       ext_mode,
  input logic             ext_explicit,
  input logic             no_flags,
  input logic [REG_W-1:0] reg_value,
  input logic             out_valid,
  input logic [REG_W-1:0] alu_operand,
  input logic [REG_W-1:0] wb_value,
  input logic             flag_we,
  input logic             flag_n,
  input logic             flag_z
);
  function automatic logic [REG_W-1:0] ref_mask(input logic [1:0] sz);
    logic [63:0] m;
    m = (64'd1 << (8 << sz)) - 64'd1;
    return m[REG_W-1:0];
  endfunction

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  assert_none_keeps_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_class) == 2'b01 && $past(ext_explicit) && $past(ext_mode) == 2'b00)
    |-> (((wb_value ^ $past(reg_value)) & ~ref_mask($past(op_size))) == '0));

  assert_load_default_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_class) == 2'b01 && !$past(ext_explicit))
    |-> ((wb_value & ~ref_mask($past(op_size))) == '0));

  assert_ones_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_class) != 2'b11 && $past(ext_explicit) && $past(ext_mode) == 2'b11)
    |-> ((alu_operand | ref_mask($past(op_size))) == '1));

  assert_noflags_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(no_flags) && $past(op_class) != 2'b10) |-> !flag_we);

  assert_cmp_writes_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_class) == 2'b10) |-> flag_we);

  assert_flags_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |-> (!flag_n && !flag_z));

  assert_store_untouched_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_class) == 2'b11) |-> (!flag_we && wb_value == $past(reg_value)));
endmodule

bind lx_unit lx_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .op_class     (op_class),
  .op_size      (op_size),
  .ext_mode     (ext_mode),
  .ext_explicit (ext_explicit),
  .no_flags     (no_flags),
  .reg_value    (reg_value),
  .out_valid    (out_valid),
  .alu_operand  (alu_operand),
  .wb_value     (wb_value),
  .flag_we      (flag_we),
  .flag_n       (flag_n),
  .flag_z       (flag_z)
);

// File: tb/tb_lx_unit.sv
`timescale 1ns/1ps
module tb_lx_unit;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    op_class = '0, op_size = '0, ext_mode = '0;
  logic          ext_explicit = 1'b0, no_flags = 1'b0;
  logic [63:0]   operand = '0;
  logic [RW-1:0] reg_value = '0, alu_result = '0;
  logic          out_valid, flag_we, flag_n, flag_z;
  logic [RW-1:0] alu_operand, wb_value;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lx_unit #(.REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
    .op_size(op_size), .ext_mode(ext_mode), .ext_explicit(ext_explicit),
    .no_flags(no_flags), .operand(operand), .reg_value(reg_value),
    .alu_result(alu_result), .out_valid(out_valid), .alu_operand(alu_operand),
    .wb_value(wb_value), .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z)
  );

  // Expected values for the operation presented in the previous cycle.
  logic          e_v, e_we, e_n, e_z;
  logic [RW-1:0] e_op, e_wb;

  task automatic model(input logic v, input logic [1:0] c, input logic [1:0] sz,
                       input logic [1:0] md, input logic ex, input logic nf,
                       input logic [63:0] opd, input logic [RW-1:0] rv,
                       input logic [RW-1:0] ar);
    int w, mode, fw;
    logic [63:0] m, full, lo, res, wb, src;
    full = (RW == 64) ? '1 : ((64'd1 << RW) - 1);
    w = 8 << sz;
    if (w > RW) w = RW;
    m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    if (c == 2'b11) mode = 0;
    else if (ex) mode = md;
    else if (c == 2'b01) mode = 2;
    else mode = 0;
    lo = (c == 2'b11 ? 64'(rv) : opd) & m;
    case (mode)
      0: res = lo | ((c == 2'b11 ? 64'd0 : 64'(rv)) & ~m);
      1: res = lo[w-1] ? (lo | ~m) : lo;
      2: res = lo;
      default: res = lo | ~m;
    endcase
    res &= full;
    if (c == 2'b01) wb = res;
    else if (c == 2'b11) wb = 64'(rv);
    else if (mode == 0) wb = (64'(ar) & m) | (64'(rv) & ~m);
    else wb = 64'(ar);
    if (c == 2'b01) begin src = opd & m; fw = w; end
    else if (mode == 0) begin src = 64'(ar) & m; fw = w; end
    else begin src = 64'(ar); fw = RW; end
    e_v  = v;
    e_op = res[RW-1:0];
    e_wb = wb[RW-1:0];
    e_we = v && c != 2'b11 && (c == 2'b10 || !nf);
    e_n  = e_we && src[fw-1];
    e_z  = e_we && (src == 64'd0);
  endtask

  task automatic check(input string tag);
    tests++;
    if (out_valid !== e_v || (e_v && (alu_operand !== e_op || wb_value !== e_wb ||
        flag_we !== e_we || flag_n !== e_n || flag_z !== e_z))) begin
      fails++;
      $display("FAIL %s: got v=%b op=%h wb=%h we=%b n=%b z=%b exp v=%b op=%h wb=%h we=%b n=%b z=%b",
               tag, out_valid, alu_operand, wb_value, flag_we, flag_n, flag_z,
               e_v, e_op, e_wb, e_we, e_n, e_z);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [1:0] c,
                      input logic [1:0] sz, input logic [1:0] md, input logic ex,
                      input logic nf, input logic [63:0] opd,
                      input logic [RW-1:0] rv, input logic [RW-1:0] ar);
    @(negedge clk);
    in_valid = v; op_class = c; op_size = sz; ext_mode = md;
    ext_explicit = ex; no_flags = nf; operand = opd; reg_value = rv; alu_result = ar;
    model(v, c, sz, md, ex, nf, opd, rv, ar);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tests++;
    if (out_valid !== 1'b0 || flag_we !== 1'b0 || flag_n !== 1'b0 || flag_z !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got v=%b we=%b n=%b z=%b exp 0 0 0 0",
               out_valid, flag_we, flag_n, flag_z);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle cycle and valid pipeline
    step("R1 idle", 1'b0, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 64'h12, 32'hAABBCCDD, '0);
    // R7/R5 default load zero-extends, flags from 8-bit value (R9)
    step("R7 load default", 1'b1, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 64'h92, 32'hAABBCCDD, '0);
    // R3 explicit no extension on load keeps upper bits
    step("R3 load none", 1'b1, 2'b01, 2'b00, 2'b00, 1'b1, 1'b0, 64'h92, 32'hAABBCCDD, '0);
    step("R3 load none 16", 1'b1, 2'b01, 2'b01, 2'b00, 1'b1, 1'b0, 64'h0000, 32'h1234FFFF, '0);
    // R4 sign extension, negative and positive at 8 and 16 bits
    step("R4 sign neg 8", 1'b1, 2'b01, 2'b00, 2'b01, 1'b1, 1'b0, 64'h92, 32'h0, '0);
    step("R4 sign pos 8", 1'b1, 2'b01, 2'b00, 2'b01, 1'b1, 1'b0, 64'h72, 32'hFFFFFFFF, '0);
    step("R4 sign neg 16", 1'b1, 2'b01, 2'b01, 2'b01, 1'b1, 1'b0, 64'h8001, 32'h0, '0);
    // R6 ones fill
    step("R6 ones 8", 1'b1, 2'b01, 2'b00, 2'b11, 1'b1, 1'b0, 64'h00, 32'h0, '0);
    step("R5 zero 16", 1'b1, 2'b01, 2'b01, 2'b10, 1'b1, 1'b0, 64'hFFFF, 32'hFFFFFFFF, '0);
    // R2 64-bit size clamps to 32 and truncates
    step("R2 clamp 64", 1'b1, 2'b01, 2'b11, 2'b10, 1'b0, 1'b0, 64'h1234567880000000, 32'h0, '0);
    step("R2 full 32", 1'b1, 2'b01, 2'b10, 2'b01, 1'b1, 1'b0, 64'h00000000, 32'h5555, '0);
    // R8/R10 other class default none: merge and narrow flags
    step("R8 other none", 1'b1, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 64'h05, 32'h11223344, 32'hABCDEF80);
    step("R10 other none zero", 1'b1, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 64'h05, 32'h11223344, 32'h7FFFFF00);
    // R8/R10 other class extended: full alu, full-width flags
    step("R10 other sign full", 1'b1, 2'b00, 2'b00, 2'b01, 1'b1, 1'b0, 64'h92, 32'h0, 32'h00000000);
    step("R10 other full neg", 1'b1, 2'b00, 2'b00, 2'b10, 1'b1, 1'b0, 64'h10, 32'h0, 32'h80000001);
    step("R10 other full nz", 1'b1, 2'b00, 2'b00, 2'b10, 1'b1, 1'b0, 64'h10, 32'h0, 32'h00000100);
    // R9 loads with extension still take narrow flags
    step("R9 load ones flags", 1'b1, 2'b01, 2'b00, 2'b11, 1'b1, 1'b0, 64'h00, 32'h0, '0);
    step("R9 load 16 neg", 1'b1, 2'b01, 2'b01, 2'b10, 1'b0, 1'b0, 64'h8000, 32'h0, '0);
    // R11 no_flags
    step("R11 nf other", 1'b1, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 64'h01, 32'h0, 32'h00000000);
    step("R11 nf load", 1'b1, 2'b01, 2'b00, 2'b00, 1'b0, 1'b1, 64'h80, 32'h0, '0);
    step("R11 nf compare", 1'b1, 2'b10, 2'b01, 2'b00, 1'b0, 1'b1, 64'h01, 32'h0, 32'h00008000);
    step("R11 compare ext", 1'b1, 2'b10, 2'b00, 2'b01, 1'b1, 1'b0, 64'hF0, 32'h0, 32'h00000000);
    // R12 stores
    step("R12 store ones", 1'b1, 2'b11, 2'b00, 2'b11, 1'b1, 1'b0, 64'hFF, 32'hDEADBEEF, 32'h0);
    step("R12 store 16", 1'b1, 2'b11, 2'b01, 2'b01, 1'b0, 1'b0, 64'h0, 32'h1234F678, 32'h0);
    step("R12 store 64", 1'b1, 2'b11, 2'b11, 2'b00, 1'b0, 1'b0, 64'h0, 32'h87654321, 32'h0);
    // R1 back to idle
    step("R1 idle end", 1'b0, 2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 64'h0, 32'h0, 32'h0);
    // Sweep of all sizes and modes for loads (R2, R4, R5, R6)
    for (int s = 0; s < 4; s++) begin
      for (int md = 0; md < 4; md++) begin
        step("R2 sweep", 1'b1, 2'b01, 2'(s), 2'(md), 1'b1, 1'b0,
             64'hF0E1D2C3B4A59687, 32'h3C3C3C3C, '0);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule